// File: doc/BRIEF.md
# Noise Shift Register for a Tone Voice

This block holds the 23-bit pseudo-random sequence that gives a tone voice its noise waveform. Each time bit 19 of the voice's phase accumulator rises, the accumulator logic sends a one-cycle strobe. The register then advances by one step two clocks later, unless another strobe arrives first. Eight non-adjacent register bits drive the upper byte of a 12-bit noise word. The lowest four bits of that word are tied to zero.

The voice's test control has three effects. It freezes the sequence. If it is held long enough, it restores the register to all ones. When it is released, the register takes one extra step, and the test level, ORed into the feedback, pushes a one into bit 0. When noise is mixed with another waveform, the voice feeds the upper byte of the mixed output back in. Any tapped register bit whose mixed output bit is zero is cleared.

Two small state machines steer the register. The shift pipeline has the states PIPE_IDLE, PIPE_ARM and PIPE_LAST, with these transitions:
- IDLE→ARM or ARM/LAST→ARM on a strobe.
- ARM→LAST when no strobe arrives.
- LAST→IDLE with a shift when no strobe arrives.
- Any state→IDLE while test is high.

The test-hold tracker has the states HOLD_RUN, HOLD_COUNT and HOLD_DONE, with these transitions:
- RUN→COUNT when test rises.
- COUNT→COUNT while counting.
- COUNT→DONE, or RUN→DONE when the hold length is 1, with the register forced to all ones.
- Any state→RUN when test is low, which gives the release shift if the tracker was not already in RUN.

Top module: `noise_lfsr_gen`

## Requirements
- R1: While `rst` is sampled high at a clock edge, the register becomes all ones (0x7FFFFF), both state machines go idle, and `noise_out` reads 0xFF0 after that edge.
- R2: `noise_out[11:4]` equal register bits 22, 20, 16, 13, 11, 7, 4, 2, listed from output bit 11 down to bit 4. `noise_out[3:0]` are always zero.
- R3: A shift loads `{reg[21:0], fb}`, where `fb` = reg[22] XOR reg[17], ORed with the release flag of R8.
- R4: A strobe sampled at edge k, with `test_hold` low, causes one shift at edge k+2 if no strobe is sampled at k+1 or k+2. A strobe never shifts the register at its own edge.
- R5: A strobe sampled while a shift is pending cancels that shift and restarts the two-edge delay from itself.
- R6: While `test_hold` is sampled high, strobes are ignored, a pending shift is dropped, and no shift takes place.
- R7: At the HOLD_CYCLES-th consecutive edge with `test_hold` high, the register is set to all ones. This overrides write-back on that edge. Later held edges do nothing more.
- R8: At the first edge with `test_hold` low after one or more edges with it high, the register shifts once, with `fb` forced to 1.
- R9: When `wb_en` is high at an edge, register bit P is cleared for each bit j where `wb_bits[j]` is 0. P is the register bit mapped to output bit 4+j in R2. The clearing happens before any shift on that same edge. Untapped bits are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Voice clock |
| rst | input | 1 | Synchronous chip reset, active high |
| acc_edge | input | 1 | One-cycle strobe: accumulator bit 19 rose |
| test_hold | input | 1 | Voice test control level |
| wb_en | input | 1 | A combined waveform including noise is selected |
| wb_bits | input | 8 | Upper byte of the combined waveform output |
| noise_out | output | 12 | Noise waveform word |

## Verification
Strobes are sent at fixed spacings of one to six cycles. This shows the gap of 3 or more that lets each shift through, apart from the gaps of 1 and 2 that keep re-arming the delay. Every 8-bit strobe pattern is also applied, followed by a quiet tail. This separates a correct two-edge delay from a delay of one or three edges and from missing re-arm logic. Test pulses of one to eight cycles, some shorter and some longer than the hold length, are applied with strobes during them. These tell a freeze apart from a forced reload, and they expose the extra one-bit step at release. Every write-back byte is applied with shifts in between, so that each tap position is checked for clearing.

// File: rtl/noise_lfsr_pkg.sv
package noise_lfsr_pkg;

    typedef enum logic [1:0] {
        PIPE_IDLE = 2'd0,
        PIPE_ARM  = 2'd1,
        PIPE_LAST = 2'd2
    } pipe_state_e;

    typedef enum logic [1:0] {
        HOLD_RUN   = 2'd0,
        HOLD_COUNT = 2'd1,
        HOLD_DONE  = 2'd2
    } hold_state_e;

    // Number of register bits routed to the noise word.
    localparam int NOISE_TAPS = 8;

    // Register bit feeding noise_out[4+j], for j = 0 .. NOISE_TAPS-1.
    localparam int TAP_POS [NOISE_TAPS] = '{2, 4, 7, 11, 13, 16, 20, 22};

endpackage

// File: rtl/noise_lfsr_pipe.sv
module noise_lfsr_pipe
    import noise_lfsr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic edge_stb,
    input  logic test_hold,
    output logic fire
);

    pipe_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (test_hold) begin
            state_d = PIPE_IDLE;
        end else if (edge_stb) begin
            state_d = PIPE_ARM;
        end else begin
            unique case (state_q)
                PIPE_IDLE: state_d = PIPE_IDLE;
                PIPE_ARM:  state_d = PIPE_LAST;
                PIPE_LAST: state_d = PIPE_IDLE;
                default:   state_d = PIPE_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= PIPE_IDLE;
        else     state_q <= state_d;
    end

    // Shift at the second edge after the strobe, unless re-armed or frozen.
    always_comb begin
        fire = (state_q == PIPE_LAST) && !test_hold && !edge_stb;
    end

endmodule

// File: rtl/noise_lfsr_hold.sv
module noise_lfsr_hold
    import noise_lfsr_pkg::*;
#(
    parameter int HOLD_CYCLES = 32768
) (
    input  logic clk,
    input  logic rst,
    input  logic test_hold,
    output logic force_set,
    output logic leave
);

    localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(HOLD_CYCLES - 1);

    hold_state_e       state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!test_hold) begin
            state_d = HOLD_RUN;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                HOLD_RUN: begin
                    if (HOLD_CYCLES <= 1) begin
                        state_d = HOLD_DONE;
                    end else begin
                        state_d = HOLD_COUNT;
                        cnt_d   = CNT_W'(1);
                    end
                end
                HOLD_COUNT: begin
                    if (cnt_q == LAST_CNT) state_d = HOLD_DONE;
                    else                   cnt_d   = cnt_q + CNT_W'(1);
                end
                HOLD_DONE: state_d = HOLD_DONE;
                default:   state_d = HOLD_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= HOLD_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        force_set = 1'b0;
        if (test_hold) begin
            unique case (state_q)
                HOLD_RUN:   force_set = (HOLD_CYCLES <= 1);
                HOLD_COUNT: force_set = (cnt_q == LAST_CNT);
                default:    force_set = 1'b0;
            endcase
        end
        leave = (state_q != HOLD_RUN) && !test_hold;
    end

endmodule

// File: rtl/noise_lfsr_core.sv
module noise_lfsr_core
    import noise_lfsr_pkg::*;
#(
    parameter int LFSR_W = 23
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  force_set,
    input  logic                  leave,
    input  logic                  fire,
    input  logic                  wb_en,
    input  logic [NOISE_TAPS-1:0] wb_bits,
    output logic [NOISE_TAPS-1:0] taps
);

    localparam int FB_HI = LFSR_W - 1;
    localparam int FB_LO = LFSR_W - 6;

    logic [LFSR_W-1:0] sr_q;
    logic [LFSR_W-1:0] keep_mask;
    logic [LFSR_W-1:0] masked;
    logic [LFSR_W-1:0] shifted;
    logic              fb;

    always_comb begin
        keep_mask = '1;
        for (int j = 0; j < NOISE_TAPS; j++) begin
            if (wb_en && !wb_bits[j]) keep_mask[TAP_POS[j]] = 1'b0;
        end
        masked  = sr_q & keep_mask;
        fb      = (masked[FB_HI] ^ masked[FB_LO]) | leave;
        shifted = {masked[LFSR_W-2:0], fb};
    end

    always_ff @(posedge clk) begin
        if (rst || force_set) sr_q <= '1;
        else if (fire || leave) sr_q <= shifted;
        else                    sr_q <= masked;
    end

    for (genvar j = 0; j < NOISE_TAPS; j++) begin : g_tap
        assign taps[j] = sr_q[TAP_POS[j]];
    end

endmodule

// File: rtl/noise_lfsr_gen.sv
module noise_lfsr_gen
    import noise_lfsr_pkg::*;
#(
    parameter int LFSR_W      = 23,
    parameter int OUT_W       = 12,
    parameter int HOLD_CYCLES = 32768
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  acc_edge,
    input  logic                  test_hold,
    input  logic                  wb_en,
    input  logic [NOISE_TAPS-1:0] wb_bits,
    output logic [OUT_W-1:0]      noise_out
);

    localparam int GND_W = OUT_W - NOISE_TAPS;

    logic                  fire;
    logic                  force_set;
    logic                  leave;
    logic [NOISE_TAPS-1:0] taps;

    noise_lfsr_pipe u_pipe (
        .clk       (clk),
        .rst       (rst),
        .edge_stb  (acc_edge),
        .test_hold (test_hold),
        .fire      (fire)
    );

    noise_lfsr_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .test_hold (test_hold),
        .force_set (force_set),
        .leave     (leave)
    );

    noise_lfsr_core #(.LFSR_W(LFSR_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .force_set (force_set),
        .leave     (leave),
        .fire      (fire),
        .wb_en     (wb_en),
        .wb_bits   (wb_bits),
        .taps      (taps)
    );

    assign noise_out[OUT_W-1 -: NOISE_TAPS] = taps;
    if (GND_W > 0) begin : g_gnd
        assign noise_out[GND_W-1:0] = '0;
    end

endmodule

// File: rtl/noise_lfsr_sva.sv
module noise_lfsr_sva
    import noise_lfsr_pkg::*;
#(
    parameter int OUT_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             acc_edge,
    input logic             test_hold,
    input logic             wb_en,
    input logic             force_set,
    input logic             leave,
    input logic [OUT_W-1:0] noise_out
);

    AST_EDGE_NO_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (acc_edge && !test_hold && !leave && !wb_en) |=> $stable(noise_out)); // R4

    AST_TEST_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (test_hold && !force_set && !wb_en) |=> $stable(noise_out)); // R6

    AST_FORCE_ONES: assert property (@(posedge clk) disable iff (rst)
        force_set |=> (&noise_out[OUT_W-1 -: NOISE_TAPS])); // R7

    AST_FORCE_NEEDS_TEST: assert property (@(posedge clk) disable iff (rst)
        force_set |-> test_hold); // R7

    AST_LEAVE_AFTER_TEST: assert property (@(posedge clk) disable iff (rst)
        leave |-> ($past(test_hold) && !test_hold)); // R8

endmodule

bind noise_lfsr_gen noise_lfsr_sva #(.OUT_W(OUT_W)) u_sva (
    .clk       (clk),
    .rst       (rst),
    .acc_edge  (acc_edge),
    .test_hold (test_hold),
    .wb_en     (wb_en),
    .force_set (force_set),
    .leave     (leave),
    .noise_out (noise_out)
);

// File: tb/sim_noise_lfsr_gen.sv
`timescale 1ns/1ps
module sim_noise_lfsr_gen;

    localparam int HOLD = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_edge = 1'b0;
    logic        test_hold = 1'b0;
    logic        wb_en = 1'b0;
    logic [7:0]  wb_bits = 8'h00;
    logic [11:0] noise_out;

    int checks = 0;
    int errors = 0;

    // Reference state, advanced from the requirements.
    logic [22:0] m;
    int          pl = 0;
    int          hc = 0;
    bit          tq = 1'b0;
    bit          armed = 1'b0;
    int          tp [8] = '{2, 4, 7, 11, 13, 16, 20, 22};

    always #4 clk = ~clk;

    noise_lfsr_gen #(.HOLD_CYCLES(HOLD)) u0 (
        .clk       (clk),
        .rst       (rst),
        .acc_edge  (acc_edge),
        .test_hold (test_hold),
        .wb_en     (wb_en),
        .wb_bits   (wb_bits),
        .noise_out (noise_out)
    );

    function automatic logic [11:0] expect_out(input logic [22:0] r);
        return {r[22], r[20], r[16], r[13], r[11], r[7], r[4], r[2], 4'b0000};
    endfunction

    task automatic check(input logic [11:0] exp_v, input string tag);
        checks++;
        if (noise_out !== exp_v) begin
            errors++;
            $display("FAIL %s: noise_out=%h expected=%h", tag, noise_out, exp_v);
        end
    endtask

    task automatic model_edge(input bit r, input bit e, input bit t,
                              input bit w, input logic [7:0] wb);
        logic [22:0] x;
        bit sh;
        bit fo;
        if (r) begin
            m = '1; pl = 0; hc = 0; tq = 1'b0;
            return;
        end
        x = m;
        if (w) for (int j = 0; j < 8; j++) if (!wb[j]) x[tp[j]] = 1'b0;  // R9
        sh = 1'b0;
        fo = 1'b0;
        if (t) begin
            pl = 0;
            hc++;
        end else begin
            hc = 0;
            if (tq) begin sh = 1'b1; fo = 1'b1; end                  // R8
            if (e) pl = 2;
            else if (pl != 0) begin
                pl--;
                if (pl == 0) sh = 1'b1;
            end
        end
        if (t && hc == HOLD) x = '1;                                  // R7
        else if (sh) x = {x[21:0], (x[22] ^ x[17]) | fo};             // R3
        m  = x;
        tq = t;
    endtask

    task automatic step(input bit r, input bit e, input bit t, input bit w,
                        input logic [7:0] wb, input string tag);
        @(negedge clk);
        if (armed) check(expect_out(m), tag);
        rst = r; acc_edge = e; test_hold = t; wb_en = w; wb_bits = wb;
        @(posedge clk);
        #1;
        model_edge(r, e, t, w, wb);
        armed = 1'b1;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: run did not end");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 8'h00, "R1 reset");
        step(0, 0, 0, 0, 8'h00, "R1 reset");
        @(negedge clk);
        check(12'hFF0, "R1 reset value");

        // Fixed strobe spacings.
        for (int gap = 1; gap <= 6; gap++) begin
            for (int n = 0; n < 30; n++) begin
                step(0, 1, 0, 0, 8'h00, "R2 R3 R4 gap sweep");
                for (int g = 1; g < gap; g++) step(0, 0, 0, 0, 8'h00, "R2 R3 R4 gap sweep");
            end
        end
        for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 8'h00, "R4 tail");

        // Every 8-cycle strobe pattern.
        for (int p = 0; p < 256; p++) begin
            for (int b = 0; b < 8; b++) step(0, p[b], 0, 0, 8'h00, "R5 pattern");
            for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 8'h00, "R5 pattern");
        end

        // Test pulses shorter and longer than the hold length.
        for (int n = 1; n <= 8; n++) begin
            for (int i = 0; i < 9; i++) step(0, (i % 3) == 0, 0, 0, 8'h00, "R6 R7 R8 test hold");
            step(0, 1, 0, 0, 8'h00, "R6 pending before test");
            for (int i = 0; i < n; i++) step(0, i[0] ^ n[0], 1, 0, 8'h00, "R6 R7 test hold");
            step(0, n[1], 0, 0, 8'h00, "R8 release");
            for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 8'h00, "R8 after release");
        end

        // Write-back of every combined byte.
        for (int v = 0; v < 256; v++) begin
            step(0, v[0], 0, 1, v[7:0], "R9 write back");
            step(0, 0, 0, 0, 8'h00, "R9 write back");
            step(0, 0, 0, v[3], 8'hFF, "R9 write back");
            if ((v % 32) == 31) begin
                step(0, 0, 1, 1, 8'h5A, "R7 R9 write back under test");
                for (int i = 0; i < HOLD; i++) step(0, 0, 1, 1, 8'h00, "R7 force over write back");
                step(0, 0, 0, 0, 8'h00, "R8 release");
            end
        end

        step(1, 1, 0, 0, 8'h00, "R1 reset");
        step(0, 0, 0, 0, 8'h00, "R1 reset");
        @(negedge clk);
        check(12'hFF0, "R1 reset value mid run");
        check(expect_out(m), "R2 final");

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule